// File: doc/BRIEF.md
# Status Register and Write-Protect Arbiter

This block keeps the eight-bit status register of a serial non-volatile memory and decides whether each memory write request and each status-register write request is allowed. It receives single-cycle command pulses already decoded by the serial front end (set-enable, clear-enable, memory write, status write). With them come the target address of a memory write, the byte offered for a status write, the level of the active-low write-protect pin, and a busy flag from the write engine. A granted request is answered by a one-cycle grant pulse on the next clock, which the write engine uses to start its cycle. The status byte is always presented for the status-read path.

The block-protect field in the status register marks the upper quarter, the upper half or the whole array as read-only. A pin-enable bit decides whether the write-protect pin may veto status writes. The pin never gates memory writes. Once a status write has been granted, later pin activity cannot withdraw it. While the write engine is busy, every command pulse is ignored; only the status read, which needs no pulse, stays available. Reset stands for power-on: all bits return to zero.

Top module: `sr_wp_arbiter`

## Requirements
- R1: After reset the status byte reads 0x00 while busy is low, and neither grant is asserted.
- R2: The status byte is laid out as bit7 = pin-enable, bits 6..4 = 0, bits 3..2 = block-protect field, bit1 = write-enable latch, bit0 = the busy input (1 = busy), and bit0 follows busy in the same cycle.
- R3: An accepted set-enable pulse sets the write-enable latch and an accepted clear-enable pulse clears it; the new value shows in the status byte one clock after the pulse.
- R4: A memory write or status write requested while the write-enable latch is 0 gives no grant and changes no status bit.
- R5: With the address A of width ADDR_W, block-protect 00 locks nothing, 01 locks A whose two top bits are 11, 10 locks A whose top bit is 1, and 11 locks every A; a write to a locked address gives no grant and leaves the write-enable latch set.
- R6: A memory write that is enabled and not locked raises write_grant for exactly the one cycle after the request, and the write-enable latch reads 0 in that same cycle.
- R7: A granted status write raises wrsr_grant for the one cycle after the request and loads pin-enable from data bit 7 and block-protect from data bits 3..2; data bits 6..4, 1 and 0 are ignored, and the write-enable latch is cleared.
- R8: When pin-enable is 1 and wp_n is low at the request, a status write is rejected with no change of any bit; wp_n has no effect on memory writes, nor on status writes while pin-enable is 0.
- R9: wp_n is looked at only in the cycle of the status-write request; taking it low afterwards does not withdraw the grant or the loaded bits.
- R10: While busy is high, every command pulse is ignored: no grant, and the write-enable latch keeps its value.
- R11: When several pulses arrive in one cycle only the highest acts, in the order status write, memory write, clear-enable, set-enable; a rejected higher request does not let a lower one act.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-on |
| cmd_wren | input | 1 | Set-enable command pulse |
| cmd_wrdi | input | 1 | Clear-enable command pulse |
| cmd_write | input | 1 | Memory write request pulse |
| cmd_wrsr | input | 1 | Status write request pulse |
| wr_addr | input | ADDR_W | Target address of the memory write |
| wrsr_data | input | 8 | Byte offered by the status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| busy | input | 1 | Write engine busy flag |
| write_grant | output | 1 | One-cycle grant of a memory write |
| wrsr_grant | output | 1 | One-cycle grant of a status write |
| status_byte | output | 8 | Current status byte |

## Verification
The arbitration is first driven with directed sequences: requests with the latch clear, each protect setting with addresses just below and just at its lowest locked address, status writes with the pin low under both settings of pin-enable, the pin dropping right after a granted status write, busy-masked pulses and stacked pulses. These separate a wrong boundary in the range decode, a pin that gates the wrong command, and a priority that lets a lower command slip past a rejected one. Seeded random traffic then mixes all pulses, addresses, pin levels and busy so that every order of enable, protect change and write is reached and compared each cycle against a reference model.

// File: rtl/sr_wp_pkg.sv
package sr_wp_pkg;

  localparam int STAT_W   = 8;
  localparam int POS_PEN  = 7;
  localparam int POS_BPHI = 3;
  localparam int POS_BPLO = 2;
  localparam int POS_WEN  = 1;
  localparam int POS_RB   = 0;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;

  typedef struct packed {
    logic  pen;
    prot_e bp;
  } nv_t;

  // Pick the retained fields out of an offered status byte.
  function automatic nv_t nv_from_byte(input logic [STAT_W-1:0] d);
    nv_t n;
    n.pen = d[POS_PEN];
    n.bp  = prot_e'(d[POS_BPHI:POS_BPLO]);
    return n;
  endfunction

  // Assemble the readable status byte.
  function automatic logic [STAT_W-1:0] status_pack(input nv_t n, input logic wen,
                                                     input logic rb);
    logic [STAT_W-1:0] s;
    s = '0;
    s[POS_PEN]            = n.pen;
    s[POS_BPHI:POS_BPLO]  = n.bp;
    s[POS_WEN]            = wen;
    s[POS_RB]             = rb;
    return s;
  endfunction

endpackage

// File: rtl/swp_range_decode.sv
module swp_range_decode
  import sr_wp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  prot_e             bp,
  input  logic [ADDR_W-1:0] addr,
  output logic              locked
);
  localparam int AW1 = ADDR_W + 1;
  localparam logic [AW1-1:0] SPAN = AW1'(1) << ADDR_W;

  // Lowest locked address for a protect setting; SPAN means nothing locked.
  function automatic logic [AW1-1:0] lock_base(input prot_e p);
    case (p)
      PROT_QTR:  return SPAN - (SPAN >> 2);
      PROT_HALF: return SPAN >> 1;
      PROT_ALL:  return '0;
      default:   return SPAN;
    endcase
  endfunction

  assign locked = ({1'b0, addr} >= lock_base(bp));
endmodule

// File: rtl/swp_cmd_arb.sv
module swp_cmd_arb (
  input  logic cmd_wren,
  input  logic cmd_wrdi,
  input  logic cmd_write,
  input  logic cmd_wrsr,
  input  logic busy,
  input  logic wen,
  input  logic pen,
  input  logic wp_n,
  input  logic locked,
  output logic take_wren,
  output logic take_wrdi,
  output logic take_write,
  output logic take_wrsr,
  output logic pin_veto
);
  logic sel_wrsr, sel_write, sel_wrdi, sel_wren;

  // Priority chooses among requests, before any acceptance test.
  assign sel_wrsr  = cmd_wrsr  & ~busy;
  assign sel_write = cmd_write & ~cmd_wrsr & ~busy;
  assign sel_wrdi  = cmd_wrdi  & ~cmd_write & ~cmd_wrsr & ~busy;
  assign sel_wren  = cmd_wren  & ~cmd_wrdi & ~cmd_write & ~cmd_wrsr & ~busy;

  assign pin_veto   = pen & ~wp_n;
  assign take_wrsr  = sel_wrsr & wen & ~pin_veto;
  assign take_write = sel_write & wen & ~locked;
  assign take_wrdi  = sel_wrdi;
  assign take_wren  = sel_wren;
endmodule

// File: rtl/swp_wen_latch.sv
module swp_wen_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_en,
  input  logic clr_en,
  output logic wen
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wen <= 1'b0;
    else if (clr_en) wen <= 1'b0;
    else if (set_en) wen <= 1'b1;
  end
endmodule

// File: rtl/swp_nv_bits.sv
module swp_nv_bits
  import sr_wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  nv_t  d,
  output nv_t  q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '{pen: 1'b0, bp: PROT_NONE};
    else if (load) q <= d;
  end
endmodule

// File: rtl/sr_wp_arbiter.sv
module sr_wp_arbiter
  import sr_wp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_write,
  input  logic              cmd_wrsr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wrsr_data,
  input  logic              wp_n,
  input  logic              busy,
  output logic              write_grant,
  output logic              wrsr_grant,
  output logic [7:0]        status_byte
);
  // Named internal events, visible to the bound checker.
  logic wen, locked, pin_veto;
  logic take_wren, take_wrdi, take_write, take_wrsr;
  nv_t  nv_q;

  swp_range_decode #(.ADDR_W(ADDR_W)) u_range (
    .bp     (nv_q.bp),
    .addr   (wr_addr),
    .locked (locked)
  );

  swp_cmd_arb u_arb (
    .cmd_wren   (cmd_wren),
    .cmd_wrdi   (cmd_wrdi),
    .cmd_write  (cmd_write),
    .cmd_wrsr   (cmd_wrsr),
    .busy       (busy),
    .wen        (wen),
    .pen        (nv_q.pen),
    .wp_n       (wp_n),
    .locked     (locked),
    .take_wren  (take_wren),
    .take_wrdi  (take_wrdi),
    .take_write (take_write),
    .take_wrsr  (take_wrsr),
    .pin_veto   (pin_veto)
  );

  swp_wen_latch u_wen (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (take_wren),
    .clr_en (take_wrdi | take_write | take_wrsr),
    .wen    (wen)
  );

  swp_nv_bits u_nv (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (take_wrsr),
    .d     (nv_from_byte(wrsr_data)),
    .q     (nv_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      write_grant <= 1'b0;
      wrsr_grant  <= 1'b0;
    end else begin
      write_grant <= take_write;
      wrsr_grant  <= take_wrsr;
    end
  end

  assign status_byte = status_pack(nv_q, wen, busy);
endmodule

// File: rtl/sr_wp_checker.sv
module sr_wp_checker #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_wren,
  input logic              cmd_wrdi,
  input logic              cmd_write,
  input logic              cmd_wrsr,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wrsr_data,
  input logic              wp_n,
  input logic              busy,
  input logic              write_grant,
  input logic              wrsr_grant,
  input logic [7:0]        status_byte
);
  logic [1:0] top2;
  logic       chk_locked;
  assign top2 = wr_addr[ADDR_W-1:ADDR_W-2];
  assign chk_locked = (status_byte[3:2] == 2'b11) ||
                      (status_byte[3:2] == 2'b10 && top2[1]) ||
                      (status_byte[3:2] == 2'b01 && top2 == 2'b11);

  assert_grants_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(write_grant && wrsr_grant));

  assert_unused_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[6:4] == 3'b000 && status_byte[0] == busy);

  assert_wren_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !cmd_wrdi && !cmd_write && !cmd_wrsr && !busy) |=> status_byte[1]);

  assert_no_grant_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_byte[1]) |=> (!write_grant && !wrsr_grant));

  assert_locked_write_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && !cmd_wrsr && chk_locked) |=> !write_grant);

  assert_write_clears_wen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    write_grant |-> !status_byte[1]);

  assert_wrsr_loads_pen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wrsr_grant |-> (status_byte[7] == $past(wrsr_data[7]) &&
                    status_byte[3:2] == $past(wrsr_data[3:2]) && !status_byte[1]));

  assert_pin_blocks_wrsr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wrsr && !wp_n && status_byte[7]) |=> (!wrsr_grant && $stable(status_byte[7:1])));

  assert_busy_masks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!write_grant && !wrsr_grant && status_byte[1] == $past(status_byte[1])));
endmodule

bind sr_wp_arbiter sr_wp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_wren    (cmd_wren),
  .cmd_wrdi    (cmd_wrdi),
  .cmd_write   (cmd_write),
  .cmd_wrsr    (cmd_wrsr),
  .wr_addr     (wr_addr),
  .wrsr_data   (wrsr_data),
  .wp_n        (wp_n),
  .busy        (busy),
  .write_grant (write_grant),
  .wrsr_grant  (wrsr_grant),
  .status_byte (status_byte)
);

// File: tb/tb_sr_wp_arbiter.sv
module tb_sr_wp_arbiter;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_wren, cmd_wrdi, cmd_write, cmd_wrsr;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wrsr_data;
  logic          wp_n, busy;
  logic          write_grant, wrsr_grant;
  logic [7:0]    status_byte;

  always #5 clk = ~clk;

  sr_wp_arbiter #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi),
    .cmd_write(cmd_write), .cmd_wrsr(cmd_wrsr), .wr_addr(wr_addr),
    .wrsr_data(wrsr_data), .wp_n(wp_n), .busy(busy),
    .write_grant(write_grant), .wrsr_grant(wrsr_grant), .status_byte(status_byte)
  );

  int checks = 0;
  int failures = 0;

  // Reference state
  bit       m_wen, m_pen;
  bit [1:0] m_bp;

  function automatic bit ref_locked(input bit [1:0] bp, input logic [AW-1:0] a);
    case (bp)
      2'd1:    return a[AW-1] & a[AW-2];
      2'd2:    return a[AW-1];
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] ref_status(input bit b);
    return {m_pen, 3'b000, m_bp, m_wen, b};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input bit wren, input bit wrdi, input bit wr,
                      input bit sr, input logic [AW-1:0] a, input logic [7:0] d,
                      input bit wpn, input bit bsy);
    bit eg, sg;
    @(negedge clk);
    cmd_wren = wren; cmd_wrdi = wrdi; cmd_write = wr; cmd_wrsr = sr;
    wr_addr = a; wrsr_data = d; wp_n = wpn; busy = bsy;
    eg = 1'b0; sg = 1'b0;
    if (!bsy) begin
      if (sr) begin
        if (m_wen && !(m_pen && !wpn)) begin
          sg = 1'b1; m_pen = d[7]; m_bp = d[3:2]; m_wen = 1'b0;
        end
      end else if (wr) begin
        if (m_wen && !ref_locked(m_bp, a)) begin
          eg = 1'b1; m_wen = 1'b0;
        end
      end else if (wrdi) m_wen = 1'b0;
      else if (wren)     m_wen = 1'b1;
    end
    @(posedge clk);
    #1;
    check({tag, " status"}, status_byte, ref_status(bsy));
    check({tag, " write_grant"}, {7'd0, write_grant}, {7'd0, eg});
    check({tag, " wrsr_grant"}, {7'd0, wrsr_grant}, {7'd0, sg});
  endtask

  task automatic idle(input string tag, input bit wpn);
    step(tag, 0, 0, 0, 0, '0, 8'h00, wpn, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 1'b0;
    cmd_wren = 0; cmd_wrdi = 0; cmd_write = 0; cmd_wrsr = 0;
    wr_addr = '0; wrsr_data = '0; wp_n = 1'b1; busy = 1'b0;
    m_wen = 0; m_pen = 0; m_bp = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 reset status", status_byte, 8'h00);
    check("R1 reset grants", {6'd0, write_grant, wrsr_grant}, 8'h00);

    // R4: requests with the latch clear
    step("R4 write disabled", 0, 0, 1, 0, 12'h010, 8'h00, 1, 0);
    step("R4 wrsr disabled",  0, 0, 0, 1, '0, 8'hFF, 1, 0);
    // R3: latch set and clear
    step("R3 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R3 wrdi", 0, 1, 0, 0, '0, 8'h00, 1, 0);
    step("R3 wren again", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    // R6: plain write
    step("R6 write granted", 0, 0, 1, 0, 12'h123, 8'h00, 1, 0);
    // R7: status write ignores bits 6..4, 1, 0
    step("R7 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R7 wrsr 7B", 0, 0, 0, 1, '0, 8'h7B, 1, 0);
    // R5: half protected, boundary 0x800
    step("R5 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R5 half locked 800", 0, 0, 1, 0, 12'h800, 8'h00, 1, 0);
    step("R5 half open 7FF", 0, 0, 1, 0, 12'h7FF, 8'h00, 1, 0);
    // R5: quarter protected with pin-enable set, boundary 0xC00
    step("R5 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R5 wrsr 84", 0, 0, 0, 1, '0, 8'h84, 1, 0);
    step("R5 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R5 qtr open BFF", 0, 0, 1, 0, 12'hBFF, 8'h00, 1, 0);
    step("R5 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R5 qtr locked C00", 0, 0, 1, 0, 12'hC00, 8'h00, 1, 0);
    // R8: pin low with pin-enable set
    step("R8 wrsr vetoed", 0, 0, 0, 1, '0, 8'h00, 0, 0);
    step("R8 write not gated", 0, 0, 1, 0, 12'h000, 8'h00, 0, 0);
    // R9: pin drops right after a granted status write
    step("R9 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R9 wrsr 0C", 0, 0, 0, 1, '0, 8'h0C, 1, 0);
    idle("R9 pin low after grant", 0);
    // R8: pin-enable clear, pin low does not veto
    step("R8 wren", 1, 0, 0, 0, '0, 8'h00, 0, 0);
    step("R8 wrsr pen0 pin low", 0, 0, 0, 1, '0, 8'h80, 0, 0);
    step("R8 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R8 wrsr clear", 0, 0, 0, 1, '0, 8'h00, 1, 0);
    // R10: busy masks everything
    step("R10 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R10 busy wrdi", 0, 1, 0, 0, '0, 8'h00, 1, 1);
    step("R10 busy write", 0, 0, 1, 0, 12'h001, 8'h00, 1, 1);
    step("R10 busy wrsr", 0, 0, 0, 1, '0, 8'h8C, 1, 1);
    // R11: stacked pulses
    step("R11 wrsr over write and wren", 1, 0, 1, 1, 12'h000, 8'h04, 1, 0);
    step("R11 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R11 write over wrdi and wren", 1, 1, 1, 0, 12'h000, 8'h00, 1, 0);
    step("R11 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R11 wrdi over wren", 1, 1, 0, 0, '0, 8'h00, 1, 0);
    step("R11 wren", 1, 0, 0, 0, '0, 8'h00, 1, 0);
    step("R11 locked write blocks wrdi", 0, 1, 1, 0, 12'hFFF, 8'h00, 1, 0);

    // Seeded random traffic: R2 R3 R5 R6 R7 R8 R10 R11
    for (int i = 0; i < 800; i++) begin
      bit [3:0] p;
      p = 4'($urandom);
      step("R2 R5 R6 R7 R8 R10 R11 random",
           ($urandom % 3) == 0, ($urandom % 6) == 0, p[0] & p[1], p[2] & p[3],
           AW'($urandom), 8'($urandom), ($urandom % 3) != 0, ($urandom % 4) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule